// File: doc/BRIEF.md
# Device Mailbox Register Interface

This block is the register front end of a device command mailbox. It sits on a simple byte-addressed bus where every access carries a size of 1, 2, 4 or 8 bytes. It holds a read-only capability word, a control word carrying the doorbell, a 64-bit command word, a 64-bit status word, an always-zero background status word, and a payload buffer. Reads at any size return little-endian bytes from the addressed location. Writes below the payload base are filtered by register and by width. Writes inside the payload are stored byte for byte.

When software sets the doorbell, the block gives a one-cycle start pulse to an external command engine. It keeps the command word and payload frozen until the engine reports completion. The completion carries a 16-bit return code. The block places that code in the status word and releases the doorbell.

Map (byte offsets): capability 0x00 (4 bytes), control 0x04 (4 bytes, doorbell in bit 0), command 0x08 (8 bytes), status 0x10 (8 bytes), background status 0x18 (8 bytes), payload 0x20 up to 0x20 + 2^PLD_SHIFT (exclusive).

Top module: `mbx_regif`

## Requirements
- R1: A read whose address is a multiple of its size and lies below the payload end returns, on the following cycle, `bus_rvalid` high and the addressed bytes in little-endian order in the low bytes of `bus_rdata`, with the upper bytes zero. The size encoding is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R2: An access that is not size-aligned, or that lies at or above the payload end, pulses `bus_err` on the following cycle. It stores nothing, and if it is a read it returns `bus_rdata` of zero with `bus_rvalid` high.
- R3: An aligned write at or above offset 0x20 stores exactly the written bytes into the payload, at any size, when the doorbell is clear.
- R4: A 4-byte write to offset 0x04 stores the control word. A 4-byte write to any other offset below 0x20 is ignored without an error.
- R5: An 8-byte write to offset 0x08 stores the command word, which is also driven on `eng_cmd`. 8-byte writes to offsets 0x00, 0x10 and 0x18 are dropped without an error.
- R6: A 1-byte or 2-byte write below offset 0x20 changes nothing and pulses `bus_err` for one cycle.
- R7: The capability word reads 0x0000000B. Bits [4:0] hold the payload size as a power-of-two shift (11, i.e. 2048 bytes). Bit 5 (interrupt support) and bit 6 (background command support) are zero. Writes never change it.
- R8: Writing control with bit 0 set while the doorbell is clear sets the doorbell. `eng_start` is high for exactly the one cycle that follows that write. Software cannot clear the doorbell.
- R9: `eng_done` while the doorbell is set loads `eng_rc` into status bits [47:32], with all other status bits zero, and clears the doorbell; both show on the next cycle. `eng_done` while the doorbell is clear has no effect.
- R10: Status changes only through R9, and the background status word at 0x18 always reads zero.
- R11: While the doorbell is set, writes to the command word and to the payload are ignored.
- R12: After reset, every stored word and all payload bytes are zero except the capability word, and `bus_rvalid`, `bus_err` and `eng_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_size | input | 2 | log2 of the access size in bytes |
| bus_wdata | input | 64 | Write data, right-justified |
| bus_rvalid | output | 1 | Read result valid (one cycle after the read) |
| bus_rdata | output | 64 | Read data, right-justified |
| bus_err | output | 1 | One-cycle error pulse for a rejected access |
| eng_start | output | 1 | One-cycle command start pulse to the engine |
| eng_cmd | output | 64 | Current command word |
| eng_done | input | 1 | Engine completion strobe |
| eng_rc | input | 16 | Engine return code, valid with `eng_done` |

## Verification
Every result of this block is due exactly one clock after the edge that samples the access or the completion strobe. This holds for the read data and its valid, for the error pulse, and for the stored command, status and doorbell. The start pulse is due in the first cycle in which the doorbell reads as set. The bench therefore keeps a behavioural model that consumes the same sampled inputs at each rising edge and produces the outputs expected for the following cycle. It compares them against the design 2 ns after that edge, while all inputs change only on falling edges. Back-to-back accesses, writes issued while a command is in flight, and a completion arriving when no command is pending all fall on this one-cycle grid.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Register offsets; software and the engine depend on these positions.
    localparam int OFS_CAP  = 0;
    localparam int OFS_CTRL = 4;
    localparam int OFS_CMD  = 8;
    localparam int OFS_STS  = 16;
    localparam int OFS_BG   = 24;
    localparam int PLD_BASE = 32;

    // Return code position inside the status word.
    localparam int RC_LSB = 32;
    localparam int RC_W   = 16;

    // Capability word field positions.
    localparam int CAP_IRQ_BIT = 5;
    localparam int CAP_BG_BIT  = 6;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic rd;       // accepted-or-not read request
        logic err;      // access rejected, error pulse due
        logic bad;      // misaligned or out of range
        logic in_pld;   // address falls in the payload window
        logic wr_pld;   // payload bytes are written
        logic wr_ctrl;  // control word is written
        logic wr_cmd;   // command word is written
    } acc_dec_t;

    function automatic logic [7:0] lane_mask(acc_size_e sz);
        case (sz)
            SZ_1B:   return 8'h01;
            SZ_2B:   return 8'h03;
            SZ_4B:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] data_mask(acc_size_e sz);
        case (sz)
            SZ_1B:   return 64'h0000_0000_0000_00FF;
            SZ_2B:   return 64'h0000_0000_0000_FFFF;
            SZ_4B:   return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [2:0] align_mask(acc_size_e sz);
        case (sz)
            SZ_1B:   return 3'b000;
            SZ_2B:   return 3'b001;
            SZ_4B:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [31:0] cap_value(logic [4:0] shift);
        logic [31:0] v;
        v = '0;
        v[4:0] = shift;
        v[CAP_IRQ_BIT] = 1'b0;
        v[CAP_BG_BIT]  = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PLD_BYTES = 2048
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              busy,
    output acc_dec_t          dec
);
    localparam logic [ADDR_W:0]   END_ADDR = (ADDR_W+1)'(PLD_BASE + PLD_BYTES);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(PLD_BASE);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    logic misalign;
    logic beyond;
    logic in_pld;
    logic bad;
    logic narrow_reg_wr;
    logic wr_ok;

    always_comb begin
        misalign      = |(addr[2:0] & align_mask(size));
        beyond        = {1'b0, addr} >= END_ADDR;
        in_pld        = addr >= BASE;
        bad           = misalign | beyond;
        narrow_reg_wr = we & ~in_pld & ((size == SZ_1B) | (size == SZ_2B));
        wr_ok         = req & we & ~bad;

        dec.rd      = req & ~we;
        dec.err     = req & (bad | narrow_reg_wr);
        dec.bad     = bad;
        dec.in_pld  = in_pld;
        dec.wr_pld  = wr_ok & in_pld & ~busy;
        dec.wr_ctrl = wr_ok & ~in_pld & (size == SZ_4B) & (addr == A_CTRL);
        dec.wr_cmd  = wr_ok & ~in_pld & (size == SZ_8B) & (addr == A_CMD) & ~busy;
    end

endmodule

// File: rtl/mbx_payload.sv
module mbx_payload #(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       be,
    input  logic [63:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [63:0]      rword
);
    // One narrow array per byte lane so byte enables need no read-modify-write.
    for (genvar l = 0; l < 8; l++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++) begin
                    lane_mem[i] <= '0;
                end
            end else if (wr_en && be[l]) begin
                lane_mem[widx] <= wdata[8*l +: 8];
            end
        end

        assign rword[8*l +: 8] = lane_mem[ridx];
    end

endmodule

// File: rtl/mbx_ctrl_regs.sv
module mbx_ctrl_regs
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic        wr_cmd,
    input  logic [63:0] wdata,
    input  logic        eng_done,
    input  logic [15:0] eng_rc,
    output logic [31:0] ctrl_word,
    output logic [63:0] cmd_q,
    output logic [63:0] sts_q,
    output logic        db_q,
    output logic        eng_start
);
    logic [31:1] ctrl_hi_q;
    logic        db_nxt;
    logic        ring;
    logic        finish;

    always_comb begin
        ring   = ~db_q & wr_ctrl & wdata[0];
        finish = db_q & eng_done;
        db_nxt = db_q ? ~finish : ring;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_hi_q <= '0;
            cmd_q     <= '0;
            sts_q     <= '0;
            db_q      <= 1'b0;
            eng_start <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_hi_q <= wdata[31:1];
            end
            if (wr_cmd) begin
                cmd_q <= wdata;
            end
            if (finish) begin
                sts_q <= '0;
                sts_q[RC_LSB +: RC_W] <= eng_rc;
            end
            db_q      <= db_nxt;
            eng_start <= db_nxt & ~db_q;
        end
    end

    assign ctrl_word = {ctrl_hi_q, db_q};

    // R8: the start strobe never lasts longer than one cycle
    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R8: without a completion the doorbell stays set
    assert_db_held_R8: assert property (@(posedge clk) disable iff (rst)
        (db_q && !eng_done) |=> db_q);

    // R9: a completion while busy releases the doorbell
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (db_q && eng_done) |=> !db_q);

    // R10: status moves only on a completion of a pending command
    assert_sts_only_done_R10: assert property (@(posedge clk) disable iff (rst)
        !(db_q && eng_done) |=> $stable(sts_q));

    // R11: command word frozen while a command is in flight
    assert_cmd_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        db_q |=> $stable(cmd_q));

endmodule

// File: rtl/mbx_regif.sv
module mbx_regif
    import mbx_pkg::*;
#(
    parameter int PLD_SHIFT = 11,
    parameter int ADDR_W    = PLD_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [63:0]       bus_rdata,
    output logic              bus_err,
    output logic              eng_start,
    output logic [63:0]       eng_cmd,
    input  logic              eng_done,
    input  logic [15:0]       eng_rc
);
    localparam int PLD_BYTES = 1 << PLD_SHIFT;
    localparam int WORDS     = PLD_BYTES / 8;
    localparam int IDX_W     = PLD_SHIFT - 3;
    localparam logic [31:0] CAP_WORD = cap_value(5'(PLD_SHIFT));

    acc_size_e         sz;
    acc_dec_t          dec;
    logic [2:0]        byte_off;
    logic [5:0]        bit_off;
    logic [63:0]       wdata_sh;
    logic [7:0]        be;
    logic [ADDR_W-1:0] pld_off;
    logic [IDX_W-1:0]  pld_idx;
    logic [63:0]       pld_word;
    logic [63:0]       reg_word;
    logic [63:0]       sel_word;
    logic [63:0]       rd_val;

    logic [31:0] ctrl_word;
    logic [63:0] cmd_q;
    logic [63:0] sts_q;
    logic        db_q;

    logic        rvalid_q;
    logic [63:0] rdata_q;
    logic        err_q;

    assign sz = acc_size_e'(bus_size);

    mbx_decode #(
        .ADDR_W    (ADDR_W),
        .PLD_BYTES (PLD_BYTES)
    ) u_decode (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .size (sz),
        .busy (db_q),
        .dec  (dec)
    );

    always_comb begin
        byte_off = bus_addr[2:0];
        bit_off  = {byte_off, 3'b000};
        wdata_sh = bus_wdata << bit_off;
        be       = lane_mask(sz) << byte_off;
        pld_off  = bus_addr - ADDR_W'(PLD_BASE);
        pld_idx  = pld_off[PLD_SHIFT-1:3];
    end

    mbx_payload #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_payload (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dec.wr_pld),
        .widx  (pld_idx),
        .be    (be),
        .wdata (wdata_sh),
        .ridx  (pld_idx),
        .rword (pld_word)
    );

    mbx_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (dec.wr_ctrl),
        .wr_cmd    (dec.wr_cmd),
        .wdata     (bus_wdata),
        .eng_done  (eng_done),
        .eng_rc    (eng_rc),
        .ctrl_word (ctrl_word),
        .cmd_q     (cmd_q),
        .sts_q     (sts_q),
        .db_q      (db_q),
        .eng_start (eng_start)
    );

    // Register window: four 64-bit words below the payload base.
    always_comb begin
        case (bus_addr[4:3])
            2'd0:    reg_word = {ctrl_word, CAP_WORD};
            2'd1:    reg_word = cmd_q;
            2'd2:    reg_word = sts_q;
            default: reg_word = '0;   // background status, always zero
        endcase
        sel_word = dec.in_pld ? pld_word : reg_word;
        rd_val   = (sel_word >> bit_off) & data_mask(sz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            rvalid_q <= dec.rd;
            rdata_q  <= (dec.rd && !dec.bad) ? rd_val : '0;
            err_q    <= dec.err;
        end
    end

    assign bus_rvalid = rvalid_q;
    assign bus_rdata  = rdata_q;
    assign bus_err    = err_q;
    assign eng_cmd    = cmd_q;

    // R2 / R6: an error pulse only follows an access
    assert_err_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_err);

    // R1: read data only shows with its valid
    assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == 64'd0));

    // R2: a rejected read returns zero
    assert_bad_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && bus_err) |-> (bus_rdata == 64'd0));

endmodule

// File: tb/test_mbx_regif.sv
module test_mbx_regif;

    localparam int PLD_SHIFT = 11;
    localparam int ADDR_W    = PLD_SHIFT + 1;
    localparam int PLD_BYTES = 1 << PLD_SHIFT;
    localparam int PEND      = 32 + PLD_BYTES;
    localparam logic [31:0] CAP_EXP = 32'h0000_000B;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_size = 2'd0;
    logic [63:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [63:0]       bus_rdata;
    logic              bus_err;
    logic              eng_start;
    logic [63:0]       eng_cmd;
    logic              eng_done = 1'b0;
    logic [15:0]       eng_rc = '0;

    int    vectors = 0;
    int    miscompares = 0;
    bit    running = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R12";

    always #4 clk = ~clk;   // 125 MHz

    mbx_regif #(.PLD_SHIFT(PLD_SHIFT)) i_mbx_regif (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .eng_start  (eng_start),
        .eng_cmd    (eng_cmd),
        .eng_done   (eng_done),
        .eng_rc     (eng_rc)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_pld [PLD_BYTES];
    logic [31:0] m_ctrl;
    logic        m_db;
    logic [63:0] m_cmd;
    logic [63:0] m_sts;
    logic        e_rvalid, e_err, e_start;
    logic [63:0] e_rdata;

    function automatic logic [7:0] m_byte(int a);
        logic [31:0] cw;
        cw = {m_ctrl[31:1], m_db};
        if (a < 4)       return CAP_EXP[8*a +: 8];
        else if (a < 8)  return cw[8*(a-4) +: 8];
        else if (a < 16) return m_cmd[8*(a-8) +: 8];
        else if (a < 24) return m_sts[8*(a-16) +: 8];
        else if (a < 32) return 8'h00;
        else             return m_pld[a-32];
    endfunction

    always @(posedge clk) begin : model
        int n;
        int a;
        bit bad;
        bit inp;
        logic db_old;
        logic db_new;
        logic [63:0] v;
        if (rst) begin
            m_db = 0; m_ctrl = 0; m_cmd = 0; m_sts = 0;
            for (int i = 0; i < PLD_BYTES; i++) m_pld[i] = 8'h00;
            e_rvalid = 0; e_rdata = 0; e_err = 0; e_start = 0;
        end else begin
            n   = 1 << bus_size;
            a   = int'(bus_addr);
            bad = ((a % n) != 0) || (a >= PEND);
            inp = (a >= 32);
            v   = 64'd0;
            if (bus_req && !bus_we && !bad)
                for (int i = 0; i < n; i++) v[8*i +: 8] = m_byte(a + i);
            e_rvalid = bus_req && !bus_we;
            e_rdata  = v;
            e_err    = bus_req && (bad || (bus_we && !inp && n < 4));
            db_old = m_db;
            db_new = m_db;
            if (bus_req && bus_we && !bad) begin
                if (inp) begin
                    if (!db_old)
                        for (int i = 0; i < n; i++) m_pld[a-32+i] = bus_wdata[8*i +: 8];
                end else if (n == 4 && a == 4) begin
                    m_ctrl = bus_wdata[31:0];
                    if (bus_wdata[0]) db_new = 1'b1;
                end else if (n == 8 && a == 8 && !db_old) begin
                    m_cmd = bus_wdata;
                end
            end
            if (eng_done && db_old) begin
                m_sts  = {16'h0000, eng_rc, 32'h0000_0000};
                db_new = 1'b0;
            end
            e_start = db_new && !db_old;
            m_db    = db_new;
        end
    end

    task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (running && !rst) begin
            vectors++;
            cmp("rvalid", 64'(bus_rvalid), 64'(e_rvalid));
            cmp("rdata",  bus_rdata, e_rdata);
            cmp("err",    64'(bus_err), 64'(e_err));
            cmp("start",  64'(eng_start), 64'(e_start));
            cmp("cmd",    eng_cmd, m_cmd);
        end
    end

    // directed check with an explicit tag
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus access, driven on the falling edge
    task automatic acc(bit we, int addr, int sz, logic [63:0] d);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = ADDR_W'(addr);
        bus_size  = 2'(sz);
        bus_wdata = d;
        @(negedge clk);
        bus_req   = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(logic [15:0] rc);
        eng_done = 1'b1;
        eng_rc   = rc;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state at the ports
        chk("R12 rvalid", 64'(bus_rvalid), 64'd0);
        chk("R12 err",    64'(bus_err), 64'd0);
        chk("R12 start",  64'(eng_start), 64'd0);
        chk("R12 cmd",    eng_cmd, 64'd0);
        running = 1'b1;
        acc(0, 16, 3, 0);       // status after reset
        acc(0, 40, 3, 0);       // payload after reset
        idle(1);

        cur_req = "R7";
        acc(0, 0, 2, 0);
        acc(0, 0, 0, 0);
        acc(0, 0, 3, 0);
        acc(1, 0, 2, 64'hFFFF_FFFF);
        acc(0, 0, 2, 0);
        idle(1);

        cur_req = "R1";
        acc(1, 32, 3, 64'h8877_6655_4433_2211);
        acc(0, 32, 3, 0);
        acc(0, 33, 0, 0);
        acc(0, 34, 1, 0);
        acc(0, 36, 2, 0);
        acc(0, 39, 0, 0);
        idle(1);

        cur_req = "R3";
        acc(1, 37, 0, 64'hFFFF_FFFF_FFFF_FFA5);
        acc(1, 42, 1, 64'h0000_0000_0000_BEEF);
        acc(1, 44, 2, 64'h0000_0000_CAFE_F00D);
        acc(1, PEND-8, 3, 64'h0123_4567_89AB_CDEF);
        acc(0, 32, 3, 0);
        acc(0, 40, 3, 0);
        acc(0, PEND-8, 3, 0);
        acc(0, PEND-1, 0, 0);
        idle(1);

        cur_req = "R2";
        acc(0, 33, 1, 0);
        acc(1, 34, 2, 64'h1111_2222);
        acc(0, 32, 3, 0);
        acc(0, PEND, 0, 0);
        acc(1, PEND + 8, 3, 64'hDEAD);
        acc(1, 12, 3, 64'hDEAD_BEEF);
        acc(0, 8, 3, 0);
        idle(1);

        cur_req = "R4";
        acc(1, 4, 2, 64'hABCD_0010);
        acc(0, 4, 2, 0);
        acc(1, 8, 2, 64'h5555_5555);
        acc(1, 12, 2, 64'h6666_6666);
        acc(1, 16, 2, 64'h7777_7777);
        acc(0, 0, 3, 0);
        acc(0, 8, 3, 0);
        acc(0, 16, 3, 0);
        idle(1);

        cur_req = "R5";
        acc(1, 8, 3, 64'hFEDC_BA98_7654_3210);
        acc(0, 8, 3, 0);
        acc(1, 16, 3, 64'h1234);
        acc(1, 24, 3, 64'h5678);
        acc(1, 0, 3, 64'h9ABC);
        acc(0, 16, 3, 0);
        acc(0, 24, 3, 0);
        acc(0, 0, 3, 0);
        idle(1);

        cur_req = "R6";
        acc(1, 4, 0, 64'h01);
        acc(1, 8, 1, 64'hAAAA);
        acc(1, 16, 0, 64'hFF);
        acc(0, 4, 2, 0);
        acc(0, 8, 3, 0);
        idle(2);

        cur_req = "R9";
        pulse_done(16'h0BAD);   // doorbell clear: ignored
        acc(0, 16, 3, 0);
        idle(1);

        cur_req = "R8";
        acc(1, 8, 3, 64'h0000_0000_0000_00C1);
        acc(1, 4, 2, 64'h0000_0001);
        seen = 1'b0;
        for (int i = 0; i < 4 && !seen; i++) begin
            if (eng_start) seen = 1'b1;
            else @(negedge clk);
        end
        chk("R8 start pulse seen", 64'(seen), 64'd1);
        acc(0, 4, 2, 0);

        cur_req = "R11";
        acc(1, 8, 3, 64'hBAD0_BAD0_BAD0_BAD0);
        acc(1, 48, 3, 64'hBAD1_BAD1_BAD1_BAD1);
        acc(1, 32, 0, 64'h00);
        acc(0, 8, 3, 0);
        acc(0, 48, 3, 0);

        cur_req = "R8";
        acc(1, 4, 2, 64'h0000_0000);     // cannot clear doorbell
        acc(0, 4, 2, 0);
        acc(1, 4, 2, 64'h0000_0001);     // no second start
        idle(3);

        cur_req = "R9";
        pulse_done(16'hA55A);
        acc(0, 16, 3, 0);
        acc(0, 20, 1, 0);
        acc(0, 4, 2, 0);
        chk("R9 doorbell released", bus_rdata, 64'h0000_0000);
        acc(0, 4, 0, 0);

        cur_req = "R10";
        acc(1, 16, 3, 64'hFFFF_FFFF_FFFF_FFFF);
        acc(0, 16, 3, 0);
        chk("R10 status kept", bus_rdata, 64'h0000_A55A_0000_0000);
        acc(0, 24, 3, 0);
        chk("R10 background zero", bus_rdata, 64'd0);

        cur_req = "R8";
        acc(1, 4, 2, 64'h0000_0003);     // second command, back-to-back done
        pulse_done(16'h0001);
        cur_req = "R9";
        acc(1, 4, 2, 64'h0000_0001);
        pulse_done(16'h7FFF);
        acc(0, 16, 3, 0);
        acc(1, 56, 3, 64'h0F0F_0F0F_0F0F_0F0F);
        acc(0, 56, 3, 0);
        idle(2);

        running  = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule